// File: doc/BRIEF.md
# Floating-point state restore sequencer

This block reloads a floating-point unit's saved state from bytes that arrive one at a time from memory. A request carries the operating mode and the operand size. These select how long the image is and how its environment header is laid out. The header carries the control, status and tag words, the instruction and data pointers, and the last opcode. Eight 80-bit stack registers follow it.

Every byte goes into shadow storage first. The architectural outputs change in a single cycle, and only after the final byte has been taken. A memory error aborts the restore at any point before that cycle and leaves the architectural state as it was. After a commit, the block raises a one-cycle exception request if the new status word holds a flag that the new control word leaves unmasked. A request made while emulation or task-switched is set is refused with a device-not-available fault.

Top module: `fpu_state_loader`

## Requirements
- R1: The image is 94 bytes when `wide_i` is 0 at start and 108 bytes when it is 1. A commit happens only after exactly that many bytes have been accepted.
- R2: In the header, slot k starts at byte k*2 (narrow) or k*4 (wide), and multi-byte values are little-endian. Slot 0 is the control word, slot 1 the status word and slot 2 the tag word, each taken from the low 16 bits of its slot. In protected layout (`real_mode_i`=0):
  - `ip_o` is slot 3, zero-extended.
  - `ip_sel_o` is slot 4 bits 15:0.
  - `opcode_o` is slot 4 bits 26:16 when wide and 0 when narrow.
  - `dp_o` is slot 5.
  - `dp_sel_o` is slot 6 bits 15:0.
- R3: In real layout (`real_mode_i`=1, also used for virtual-8086):
  - `ip_o` = {slot4[27:12], slot3[15:0]}.
  - `dp_o` = {slot6[27:12], slot5[15:0]}.
  - `opcode_o` = slot4[10:0].
  - Both selectors read 0.
  - A narrow slot reads as zero above bit 15.
- R4: The 80 bytes after the header form ST0 to ST7 in that order. Each register takes 10 bytes, little-endian, and appears on `st_o[i]`.
- R5: If the last byte is accepted at rising edge k, all restored outputs change at edge k+1, and `done_o` is high for exactly the cycle after edge k+1. At no other time do these outputs change.
- R6: A cycle with `byte_valid_i` low accepts no byte. Any number of such cycles may fall between bytes.
- R7: `fpe_o` pulses together with `done_o` when status bits 5:0 AND NOT control bits 5:0 is nonzero, and stays low otherwise.
- R8: `cc_o` = {status[14], status[10], status[9], status[8]}, which is {C3, C2, C1, C0}.
- R9: A start taken while idle with `emul_i` or `task_sw_i` set pulses `nm_fault_o` at the next edge. No restore begins, and bytes that follow are ignored.
- R10: If `mem_err_i` is high at an edge while bytes are being loaded or a commit is pending, `fault_o` pulses at that edge and no commit takes place. The block then goes idle.
- R11: `start_i` is ignored while a restore is in progress.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a restore (sampled while idle) |
| real_mode_i | input | 1 | 1 = real/virtual-8086 header layout, 0 = protected |
| wide_i | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| emul_i | input | 1 | Emulation flag |
| task_sw_i | input | 1 | Task-switched flag |
| byte_valid_i | input | 1 | `byte_i` carries the next image byte |
| byte_i | input | 8 | Image byte |
| mem_err_i | input | 1 | Memory access error |
| done_o | output | 1 | One-cycle pulse on commit |
| fault_o | output | 1 | One-cycle pulse on an aborted restore |
| nm_fault_o | output | 1 | One-cycle device-not-available pulse |
| fpe_o | output | 1 | One-cycle pending floating-point exception |
| ctrl_o | output | 16 | Control word |
| stat_o | output | 16 | Status word |
| tag_o | output | 16 | Tag word |
| cc_o | output | 4 | Condition codes {C3,C2,C1,C0} |
| ip_o | output | 32 | Instruction pointer |
| ip_sel_o | output | 16 | Instruction pointer selector |
| dp_o | output | 32 | Data pointer |
| dp_sel_o | output | 16 | Data pointer selector |
| opcode_o | output | 11 | Last opcode |
| st_o | output | 8x80 | Stack registers ST0..ST7 |

## Verification
Each result is due a fixed number of edges after the input that causes it:
- `nm_fault_o` follows the edge that samples the refused start.
- `fault_o` follows the edge that samples `mem_err_i`.
- `done_o`, `fpe_o` and every restored field follow the edge after the one that accepts the final byte.

The bench's behavioural model updates its expected values at the same rising edge that the design uses. Every output is compared at the falling edge that follows. As a result, a pulse that arrives one cycle early or late fails, and so does a field that changes before the commit cycle.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_LOAD   = 2'd1,
    S_COMMIT = 2'd2
  } load_st_e;

  localparam int SLOT_BITS = 32;
  localparam int BYTE_W    = 8;
endpackage

// File: rtl/fsl_cursor.sv
// Maps a running byte index onto a header slot/lane or a stack register/lane.
module fsl_cursor #(
  parameter int NUM_ST   = 8,
  parameter int ST_BYTES = 10,
  parameter int SLOTS    = 7,
  localparam int IDX_W   = $clog2(SLOTS * 4 + NUM_ST * ST_BYTES + 1),
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int REG_W   = $clog2(NUM_ST),
  localparam int LANE_W  = $clog2(ST_BYTES)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wide_i,
  output logic              is_hdr_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [1:0]        lane_o,
  output logic [REG_W-1:0]  reg_o,
  output logic [LANE_W-1:0] reg_lane_o,
  output logic              last_o
);
  logic [IDX_W-1:0] hdr_len, rel;

  always_comb begin
    hdr_len    = wide_i ? IDX_W'(SLOTS * 4) : IDX_W'(SLOTS * 2);
    is_hdr_o   = idx_i < hdr_len;
    slot_o     = wide_i ? SLOT_W'(idx_i >> 2) : SLOT_W'(idx_i >> 1);
    lane_o     = wide_i ? idx_i[1:0] : {1'b0, idx_i[0]};
    rel        = idx_i - hdr_len;
    reg_o      = REG_W'(rel / IDX_W'(ST_BYTES));
    reg_lane_o = LANE_W'(rel % IDX_W'(ST_BYTES));
    last_o     = idx_i == (hdr_len + IDX_W'(NUM_ST * ST_BYTES) - IDX_W'(1));
  end
endmodule

// File: rtl/fsl_shadow.sv
// Byte-addressed shadow copy of header slots and stack registers.
module fsl_shadow #(
  parameter int NUM_ST   = 8,
  parameter int ST_BYTES = 10,
  parameter int SLOTS    = 7,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int REG_W   = $clog2(NUM_ST),
  localparam int LANE_W  = $clog2(ST_BYTES),
  localparam int ST_W    = ST_BYTES * 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        we_i,
  input  logic                        is_hdr_i,
  input  logic [SLOT_W-1:0]           slot_i,
  input  logic [1:0]                  lane_i,
  input  logic [REG_W-1:0]            reg_i,
  input  logic [LANE_W-1:0]           reg_lane_i,
  input  logic [7:0]                  byte_i,
  output logic [SLOTS-1:0][31:0]      slot_q_o,
  output logic [NUM_ST-1:0][ST_W-1:0] st_q_o
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    for (genvar b = 0; b < 4; b++) begin : g_lane
      logic [7:0] q;
      // cleared at start so narrow slots read zero-extended
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   q <= '0;
        else if (clr_i)                q <= '0;
        else if (we_i && is_hdr_i && slot_i == SLOT_W'(s) && lane_i == 2'(b))
                                       q <= byte_i;
      end
      assign slot_q_o[s][b*8 +: 8] = q;
    end
  end

  for (genvar r = 0; r < NUM_ST; r++) begin : g_reg
    for (genvar b = 0; b < ST_BYTES; b++) begin : g_lane
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we_i && !is_hdr_i && reg_i == REG_W'(r) && reg_lane_i == LANE_W'(b))
                     q <= byte_i;
      end
      assign st_q_o[r][b*8 +: 8] = q;
    end
  end
endmodule

// File: rtl/fsl_pending.sv
module fsl_pending #(
  parameter int FLAG_W = 6
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] masks_i,
  output logic              pending_o
);
  assign pending_o = |(flags_i & ~masks_i);
endmodule

// File: rtl/fpu_state_loader.sv
module fpu_state_loader
  import fsl_pkg::*;
#(
  parameter int NUM_ST   = 8,
  parameter int ST_BYTES = 10,
  parameter int SLOTS    = 7,
  parameter int FLAG_W   = 6,
  localparam int ST_W    = ST_BYTES * 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        real_mode_i,
  input  logic                        wide_i,
  input  logic                        emul_i,
  input  logic                        task_sw_i,
  input  logic                        byte_valid_i,
  input  logic [7:0]                  byte_i,
  input  logic                        mem_err_i,
  output logic                        done_o,
  output logic                        fault_o,
  output logic                        nm_fault_o,
  output logic                        fpe_o,
  output logic [15:0]                 ctrl_o,
  output logic [15:0]                 stat_o,
  output logic [15:0]                 tag_o,
  output logic [3:0]                  cc_o,
  output logic [31:0]                 ip_o,
  output logic [15:0]                 ip_sel_o,
  output logic [31:0]                 dp_o,
  output logic [15:0]                 dp_sel_o,
  output logic [10:0]                 opcode_o,
  output logic [NUM_ST-1:0][ST_W-1:0] st_o
);
  localparam int IDX_W  = $clog2(SLOTS * 4 + NUM_ST * ST_BYTES + 1);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int REG_W  = $clog2(NUM_ST);
  localparam int LANE_W = $clog2(ST_BYTES);

  load_st_e state_q;
  logic [IDX_W-1:0] idx_q;
  logic real_q, wide_q;

  logic is_hdr, last, accept, we, pending;
  logic [SLOT_W-1:0] slot;
  logic [1:0] lane;
  logic [REG_W-1:0] rsel;
  logic [LANE_W-1:0] rlane;
  logic [SLOTS-1:0][31:0] sl;
  logic [NUM_ST-1:0][ST_W-1:0] st_sh;

  logic [15:0] n_ctrl, n_stat, n_tag, n_ip_sel, n_dp_sel;
  logic [31:0] n_ip, n_dp;
  logic [10:0] n_op;

  assign accept = (state_q == S_IDLE) && start_i && !(emul_i || task_sw_i);
  assign we     = (state_q == S_LOAD) && byte_valid_i && !mem_err_i;

  fsl_cursor #(.NUM_ST(NUM_ST), .ST_BYTES(ST_BYTES), .SLOTS(SLOTS)) i_cursor (
    .idx_i(idx_q), .wide_i(wide_q), .is_hdr_o(is_hdr), .slot_o(slot),
    .lane_o(lane), .reg_o(rsel), .reg_lane_o(rlane), .last_o(last)
  );

  fsl_shadow #(.NUM_ST(NUM_ST), .ST_BYTES(ST_BYTES), .SLOTS(SLOTS)) i_shadow (
    .clk_i, .rst_ni, .clr_i(accept), .we_i(we), .is_hdr_i(is_hdr),
    .slot_i(slot), .lane_i(lane), .reg_i(rsel), .reg_lane_i(rlane),
    .byte_i, .slot_q_o(sl), .st_q_o(st_sh)
  );

  // header layout select
  always_comb begin
    n_ctrl = sl[0][15:0];
    n_stat = sl[1][15:0];
    n_tag  = sl[2][15:0];
    if (real_q) begin
      n_ip     = {sl[4][27:12], sl[3][15:0]};
      n_dp     = {sl[6][27:12], sl[5][15:0]};
      n_op     = sl[4][10:0];
      n_ip_sel = '0;
      n_dp_sel = '0;
    end else begin
      n_ip     = sl[3];
      n_dp     = sl[5];
      n_op     = wide_q ? sl[4][26:16] : '0;
      n_ip_sel = sl[4][15:0];
      n_dp_sel = sl[6][15:0];
    end
  end

  logic unused_bits;
  assign unused_bits = ^{sl[0][31:16], sl[1][31:16], sl[2][31:16],
                         sl[4][31:28], sl[6][31:28]};

  fsl_pending #(.FLAG_W(FLAG_W)) i_pending (
    .flags_i(n_stat[FLAG_W-1:0]), .masks_i(n_ctrl[FLAG_W-1:0]), .pending_o(pending)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      real_q     <= 1'b0;
      wide_q     <= 1'b0;
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      nm_fault_o <= 1'b0;
      fpe_o      <= 1'b0;
    end else begin
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      nm_fault_o <= 1'b0;
      fpe_o      <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          if (emul_i || task_sw_i) nm_fault_o <= 1'b1;
          else begin
            state_q <= S_LOAD;
            idx_q   <= '0;
            real_q  <= real_mode_i;
            wide_q  <= wide_i;
          end
        end
        S_LOAD: if (mem_err_i) begin
          fault_o <= 1'b1;
          state_q <= S_IDLE;
        end else if (byte_valid_i) begin
          if (last) state_q <= S_COMMIT;
          else      idx_q   <= idx_q + IDX_W'(1);
        end
        S_COMMIT: begin
          state_q <= S_IDLE;
          if (mem_err_i) fault_o <= 1'b1;
          else begin
            done_o <= 1'b1;
            fpe_o  <= pending;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // architectural state, written only on commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      stat_o   <= '0;
      tag_o    <= '0;
      ip_o     <= '0;
      ip_sel_o <= '0;
      dp_o     <= '0;
      dp_sel_o <= '0;
      opcode_o <= '0;
      st_o     <= '0;
    end else if (state_q == S_COMMIT && !mem_err_i) begin
      ctrl_o   <= n_ctrl;
      stat_o   <= n_stat;
      tag_o    <= n_tag;
      ip_o     <= n_ip;
      ip_sel_o <= n_ip_sel;
      dp_o     <= n_dp;
      dp_sel_o <= n_dp_sel;
      opcode_o <= n_op;
      st_o     <= st_sh;
    end
  end

  assign cc_o = {stat_o[14], stat_o[10], stat_o[9], stat_o[8]};
endmodule

// File: rtl/fsl_checker.sv
module fsl_checker #(
  parameter int NUM_ST   = 8,
  parameter int ST_BYTES = 10
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic                                done_o,
  input logic                                fault_o,
  input logic                                nm_fault_o,
  input logic                                fpe_o,
  input logic [15:0]                         ctrl_o,
  input logic [15:0]                         stat_o,
  input logic [15:0]                         tag_o,
  input logic [31:0]                         ip_o,
  input logic [31:0]                         dp_o,
  input logic [NUM_ST-1:0][ST_BYTES*8-1:0]   st_o
);
  p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_until_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(ctrl_o) && $stable(stat_o) && $stable(tag_o) &&
                 $stable(ip_o) && $stable(dp_o) && $stable(st_o)));

  p_abort_no_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !done_o);

  p_fpe_with_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpe_o |-> done_o);

  p_nm_alone_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nm_fault_o |-> (!done_o && !fault_o));
endmodule

bind fpu_state_loader fsl_checker #(.NUM_ST(NUM_ST), .ST_BYTES(ST_BYTES)) i_fsl_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .fault_o(fault_o),
  .nm_fault_o(nm_fault_o), .fpe_o(fpe_o), .ctrl_o(ctrl_o), .stat_o(stat_o),
  .tag_o(tag_o), .ip_o(ip_o), .dp_o(dp_o), .st_o(st_o)
);

// File: tb/test_fpu_state_loader.sv
`timescale 1ns/1ps
module test_fpu_state_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, real_m = 0, wide = 0, emul = 0, tsw = 0, bv = 0, merr = 0;
  logic [7:0] din = '0;
  logic done_o, fault_o, nm_o, fpe_o;
  logic [15:0] ctrl_o, stat_o, tag_o, ipsel_o, dpsel_o;
  logic [3:0] cc_o;
  logic [31:0] ip_o, dp_o;
  logic [10:0] op_o;
  logic [7:0][79:0] st_o;

  int n_chk = 0, n_err = 0;
  bit fin = 0;

  always #4 clk = ~clk;

  fpu_state_loader i_fpu_state_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .real_mode_i(real_m), .wide_i(wide),
    .emul_i(emul), .task_sw_i(tsw), .byte_valid_i(bv), .byte_i(din), .mem_err_i(merr),
    .done_o(done_o), .fault_o(fault_o), .nm_fault_o(nm_o), .fpe_o(fpe_o),
    .ctrl_o(ctrl_o), .stat_o(stat_o), .tag_o(tag_o), .cc_o(cc_o), .ip_o(ip_o),
    .ip_sel_o(ipsel_o), .dp_o(dp_o), .dp_sel_o(dpsel_o), .opcode_o(op_o), .st_o(st_o)
  );

  task automatic chk(string tag, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st = 0;           // 0 idle, 1 collecting, 2 commit pending
  bit m_real, m_w;
  logic [7:0] img[$];
  logic e_done, e_fault, e_nm, e_fpe;
  logic [15:0] e_ctrl, e_stat, e_tag, e_ipsel, e_dpsel;
  logic [31:0] e_ip, e_dp;
  logic [10:0] e_op;
  logic [79:0] e_st[8];

  function automatic logic [79:0] le(int off, int n);
    logic [79:0] r = '0;
    for (int k = 0; k < n; k++) r[k*8 +: 8] = img[off+k];
    return r;
  endfunction

  task automatic m_decode();
    int hb = m_w ? 4 : 2;
    logic [31:0] s3, s4, s5, s6;
    s3 = 32'(le(3*hb, hb)); s4 = 32'(le(4*hb, hb));
    s5 = 32'(le(5*hb, hb)); s6 = 32'(le(6*hb, hb));
    e_ctrl = 16'(le(0, 2)); e_stat = 16'(le(hb, 2)); e_tag = 16'(le(2*hb, 2));
    if (m_real) begin
      e_ip = {s4[27:12], s3[15:0]}; e_dp = {s6[27:12], s5[15:0]};
      e_op = s4[10:0]; e_ipsel = '0; e_dpsel = '0;
    end else begin
      e_ip = s3; e_dp = s5; e_ipsel = s4[15:0]; e_dpsel = s6[15:0];
      e_op = m_w ? s4[26:16] : 11'd0;
    end
    for (int i = 0; i < 8; i++) e_st[i] = le(7*hb + 10*i, 10);
    e_fpe = |(e_stat[5:0] & ~e_ctrl[5:0]);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; e_done = 0; e_fault = 0; e_nm = 0; e_fpe = 0;
      e_ctrl = 0; e_stat = 0; e_tag = 0; e_ip = 0; e_dp = 0;
      e_ipsel = 0; e_dpsel = 0; e_op = 0;
      for (int i = 0; i < 8; i++) e_st[i] = '0;
    end else begin
      e_done = 0; e_fault = 0; e_nm = 0; e_fpe = 0;
      if (m_st == 0) begin
        if (start) begin
          if (emul || tsw) e_nm = 1;
          else begin m_st = 1; m_real = real_m; m_w = wide; img.delete(); end
        end
      end else if (m_st == 1) begin
        if (merr) begin e_fault = 1; m_st = 0; end
        else if (bv) begin
          img.push_back(din);
          if (img.size() == (m_w ? 108 : 94)) m_st = 2;
        end
      end else begin
        if (merr) e_fault = 1;
        else begin m_decode(); e_done = 1; end
        m_st = 0;
      end
    end
  end

  always @(negedge clk) if (!fin && rst_n) begin
    chk("R1 R5 done", 80'(done_o), 80'(e_done));
    chk("R10 fault", 80'(fault_o), 80'(e_fault));
    chk("R9 nm_fault", 80'(nm_o), 80'(e_nm));
    chk("R7 fpe", 80'(fpe_o), 80'(e_fpe));
    chk("R2 control", 80'(ctrl_o), 80'(e_ctrl));
    chk("R2 status", 80'(stat_o), 80'(e_stat));
    chk("R2 tag", 80'(tag_o), 80'(e_tag));
    chk("R2 R3 ip", 80'(ip_o), 80'(e_ip));
    chk("R2 R3 ip_sel", 80'(ipsel_o), 80'(e_ipsel));
    chk("R2 R3 dp", 80'(dp_o), 80'(e_dp));
    chk("R2 R3 dp_sel", 80'(dpsel_o), 80'(e_dpsel));
    chk("R2 R3 opcode", 80'(op_o), 80'(e_op));
    chk("R8 cc", 80'(cc_o), 80'({e_stat[14], e_stat[10], e_stat[9], e_stat[8]}));
    for (int i = 0; i < 8; i++) chk("R4 stack reg", st_o[i], e_st[i]);
  end

  // ---------------- stimulus ----------------
  task automatic run(bit rm, bit w, int stall, logic [15:0] cw, logic [15:0] sw,
                     int err_at, bit err_commit, bit restart);
    int total = w ? 108 : 94;
    int hb = w ? 4 : 2;
    logic [7:0] b[];
    b = new[total];
    for (int i = 0; i < total; i++) b[i] = 8'($urandom);
    b[0] = cw[7:0]; b[1] = cw[15:8]; b[hb] = sw[7:0]; b[hb+1] = sw[15:8];
    real_m = rm; wide = w; start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < total; i++) begin
      if (i == err_at) begin
        merr = 1; @(negedge clk); merr = 0;
        repeat (3) @(negedge clk);
        return;
      end
      if (stall > 0 && i % 2 == 1) repeat (stall) @(negedge clk);
      bv = 1; din = b[i];
      if (restart && i == 5) begin start = 1; real_m = ~rm; wide = ~w; end
      @(negedge clk);
      bv = 0; start = 0; real_m = rm; wide = w;
    end
    if (err_commit) begin merr = 1; @(negedge clk); merr = 0; end
    repeat (3) @(negedge clk);
  endtask

  task automatic refused(bit em, bit ts);
    emul = em; tsw = ts; start = 1;
    @(negedge clk); start = 0; emul = 0; tsw = 0;
    for (int i = 0; i < 20; i++) begin bv = 1; din = 8'(i); @(negedge clk); end
    bv = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R12: outputs cleared while in reset
    chk("R12 reset done", 80'(done_o), 80'(0));
    chk("R12 reset fault", 80'(fault_o), 80'(0));
    chk("R12 reset control", 80'(ctrl_o), 80'(0));
    chk("R12 reset stack", st_o[0], 80'(0));
    rst_n = 1;
    @(negedge clk);
    // R1 R2 R4: narrow protected, no gaps, all flags masked
    run(0, 0, 0, 16'h037f, 16'h0000, -1, 0, 0);
    // R6 R7 R8: wide protected with stalls, unmasked flag, condition codes set
    run(0, 1, 3, 16'h0340, 16'h4701, -1, 0, 0);
    // R3: narrow real layout, flags masked
    run(1, 0, 1, 16'h037f, 16'h0521, -1, 0, 0);
    // R3 R7: wide real layout, flag 0 unmasked
    run(1, 1, 0, 16'h037e, 16'h0201, -1, 0, 0);
    // R9: device-not-available on either flag, following bytes ignored
    refused(1, 0);
    refused(0, 1);
    // R10: memory error mid-header and mid-stack, and in the commit cycle
    run(0, 1, 0, 16'h0000, 16'h003f, 10, 0, 0);
    run(1, 0, 2, 16'h0000, 16'h003f, 60, 0, 0);
    run(0, 0, 0, 16'h0000, 16'h003f, -1, 1, 0);
    // R1: 93 of 94 bytes then abort, no commit
    run(0, 0, 0, 16'h0000, 16'h0001, 93, 0, 0);
    // R11: start during a restore is ignored
    run(0, 0, 0, 16'h0300, 16'h0004, -1, 0, 1);
    run(1, 1, 1, 16'h0000, 16'h0020, -1, 0, 1);
    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!fin) begin
      fin = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule